// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page mappings. It turns a 32-bit virtual address into a 32-bit physical address for 4 KB pages. A lookup request carries the virtual address and a flag that marks it as a store. One clock later the block returns either a hit with the translated address, or a miss flag. On a miss the access must stall. A miss handler fetches the mapping, loads it through the fill port, and then retries the access.

Each slot keeps a valid bit, a reference bit and a dirty bit. Hits update the reference and dirty bits. When a fill pushes out a live mapping, the block reports that page number and its two status bits on an eviction port, so the page table can be updated. Every slot's page number is compared in parallel. The slot to replace is chosen by least-recent use, which is tracked with one age counter per slot. A flush input drops all mappings at once, and a separate input clears every reference bit.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `lk_paddr` is the stored physical page number joined to the untranslated low 12 bits of `lk_vaddr`, presented in the cycle after the request.
- R2: Exactly one of `lk_hit` and `lk_miss` is high in the cycle after a request. Both are low in the cycle after a cycle with no request.
- R3: A request whose page number has no valid slot gives `lk_miss`. After that page is loaded through the fill port, the retried request hits.
- R4: A fill of a new page number uses the lowest-numbered invalid slot if one exists. Otherwise it replaces the slot least recently hit or filled, and that page then misses.
- R5: A fill whose page number is already present overwrites that slot with the new physical page and clears its status bits. It creates no second copy and reports no eviction.
- R6: When a fill replaces a valid slot, then in the next cycle `ev_valid` is high and `ev_vpn`, `ev_ref` and `ev_dirty` carry the replaced page number and its status bits. `ev_valid` is low after any other fill.
- R7: Any hit sets the reference bit of its slot. A pulse on `ref_clear` sets every reference bit to 0. A fill starts a slot with its reference bit at 0.
- R8: A hit with `lk_write` high sets the dirty bit of its slot. A hit with `lk_write` low leaves the dirty bit unchanged.
- R9: A pulse on `flush` invalidates every slot in one cycle. Every lookup from the next cycle on misses until a new fill is made.
- R10: A fill in the same cycle as `flush` is dropped.
- R11: After reset, all slots are invalid and `lk_hit`, `lk_miss` and `ev_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Request is a store |
| lk_vaddr | input | 32 | Virtual address |
| fill_valid | input | 1 | Load a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_ppn | input | 20 | Physical page number to load |
| ref_clear | input | 1 | Clear all reference bits |
| flush | input | 1 | Invalidate all slots |
| lk_hit | output | 1 | Previous request hit |
| lk_miss | output | 1 | Previous request missed; retry after fill |
| lk_paddr | output | 32 | Translated address (zero on miss) |
| ev_valid | output | 1 | Previous fill replaced a live mapping |
| ev_vpn | output | 20 | Replaced page number |
| ev_ref | output | 1 | Replaced slot's reference bit |
| ev_dirty | output | 1 | Replaced slot's dirty bit |

## Verification
The bench fills every slot and then hits them in a known order, so the replacement order is fixed. A design with stale or duplicated age counters would evict the wrong page, which shows up in `ev_vpn`. The eviction port also brings out the status bits. A design that marked pages dirty on reads, or ignored the reference clear, would report wrong `ev_dirty` or `ev_ref` values. Further tests cover a refill of a page that is already present, which must not report an eviction or leave a stale copy that a later fill would then displace. They also cover a flush that coincides with a fill, where a design that let the fill through would hit on the retried lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_OFF_W = 12;
  typedef struct packed {
    logic valid;
    logic refd;
    logic dirty;
  } slot_stat_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic [KEY_W-1:0] tags [ENTRIES],
  input  logic [KEY_W-1:0] key,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [ENTRIES-1:0] hitvec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitvec[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitvec[i]) idx = IDX_W'(i);
  end
  assign found = |hitvec;

  // R5: fills never leave two valid slots holding the same page
  assert_no_dup_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitvec));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == AGE_MAX);
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_vec[i]) oldest_idx = IDX_W'(i);
  end

  // R4: ages stay a permutation, so exactly one slot is the oldest
  assert_one_oldest_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 16,
  localparam int VPN_W  = VA_W - PAGE_OFF_W,
  localparam int PPN_W  = PA_W - PAGE_OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             ref_clear,
  input  logic             flush,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             ev_valid,
  output logic [VPN_W-1:0] ev_vpn,
  output logic             ev_ref,
  output logic             ev_dirty
);
  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [ENTRIES-1:0] v_q, r_q, d_q;

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_found, fill_dup, fill_go, any_free, touch;
  logic [IDX_W-1:0] lk_idx, dup_idx, free_idx, lru_idx, fill_slot, touch_idx;
  slot_stat_t       victim;

  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_OFF_W];

  tlb_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_lk_match (
    .clk(clk), .rst(rst), .valid(v_q), .tags(tag_q), .key(lk_vpn),
    .found(lk_found), .idx(lk_idx));

  tlb_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_fill_match (
    .clk(clk), .rst(rst), .valid(v_q), .tags(tag_q), .key(fill_vpn),
    .found(fill_dup), .idx(dup_idx));

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!v_q[i]) free_idx = IDX_W'(i);
  end
  assign any_free = ~&v_q;

  assign fill_go   = fill_valid && !flush;
  assign fill_slot = fill_dup ? dup_idx : (any_free ? free_idx : lru_idx);
  assign touch     = fill_go || (lk_valid && lk_found);
  assign touch_idx = fill_go ? fill_slot : lk_idx;
  assign victim    = '{valid: v_q[fill_slot], refd: r_q[fill_slot], dirty: d_q[fill_slot]};

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .oldest_idx(lru_idx));

  // mapping storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[fill_slot] <= fill_vpn;
      ppn_q[fill_slot] <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0; r_q <= '0; d_q <= '0;
      lk_hit <= 1'b0; lk_miss <= 1'b0; lk_paddr <= '0;
      ev_valid <= 1'b0; ev_vpn <= '0; ev_ref <= 1'b0; ev_dirty <= 1'b0;
    end else begin
      lk_hit  <= lk_valid && lk_found;
      lk_miss <= lk_valid && !lk_found;
      if (lk_valid)
        lk_paddr <= lk_found ? {ppn_q[lk_idx], lk_vaddr[PAGE_OFF_W-1:0]} : '0;
      if (ref_clear) r_q <= '0;
      if (lk_valid && lk_found) begin
        r_q[lk_idx] <= 1'b1;
        if (lk_write) d_q[lk_idx] <= 1'b1;
      end
      ev_valid <= fill_go && !fill_dup && victim.valid;
      ev_vpn   <= tag_q[fill_slot];
      ev_ref   <= victim.refd;
      ev_dirty <= victim.dirty;
      if (fill_go) begin
        v_q[fill_slot] <= 1'b1;
        r_q[fill_slot] <= 1'b0;
        d_q[fill_slot] <= 1'b0;
      end
      if (flush) v_q <= '0;
    end
  end

  assert_result_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (lk_hit ^ lk_miss));
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!lk_hit && !lk_miss));
  assert_offset_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (lk_miss || lk_paddr[PAGE_OFF_W-1:0] == $past(lk_vaddr[PAGE_OFF_W-1:0])));
  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lk_valid) |=> lk_miss);
  assert_ev_from_fill_R6: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(fill_valid && !flush));
endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        ref_clear = 1'b0, flush = 1'b0;
  logic        lk_hit, lk_miss, ev_valid, ev_ref, ev_dirty;
  logic [31:0] lk_paddr;
  logic [19:0] ev_vpn;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .ref_clear(ref_clear), .flush(flush),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .ev_valid(ev_valid), .ev_vpn(ev_vpn), .ev_ref(ev_ref), .ev_dirty(ev_dirty));

  function automatic logic [19:0] pf(input logic [19:0] v);
    return v ^ 20'hABCDE;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic wr);
    @(negedge clk); lk_valid = 1'b1; lk_vaddr = va; lk_write = wr;
    @(negedge clk); lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic with_flush);
    @(negedge clk); fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; flush = with_flush;
    @(negedge clk); fill_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); ref_clear = 1'b1;
    @(negedge clk); ref_clear = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 hit low", lk_hit, 0);
    chk("R11 miss low", lk_miss, 0);
    chk("R11 ev low", ev_valid, 0);
    look(32'h0000_0123, 1'b0);
    chk("R11 empty misses", lk_miss, 1);
  endtask

  task automatic t_basic();
    fill(20'h00042, pf(20'h00042), 1'b0);
    chk("R4 no ev on free slot", ev_valid, 0);
    look(32'h0004_2ABC, 1'b0);
    chk("R2 hit", {lk_hit, lk_miss}, 2'b10);
    chk("R1 paddr", lk_paddr, {pf(20'h00042), 12'hABC});
    look(32'h0004_2007, 1'b1);
    chk("R1 paddr offset", lk_paddr, {pf(20'h00042), 12'h007});
    look(32'h0004_3000, 1'b0);
    chk("R3 other page misses", {lk_hit, lk_miss}, 2'b01);
    chk("R3 miss paddr zero", lk_paddr, 0);
    @(negedge clk);
    chk("R2 idle no result", {lk_hit, lk_miss}, 2'b00);
  endtask

  task automatic t_lru_status();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      fill(20'h00100 + 20'(i), pf(20'h00100 + 20'(i)), 1'b0);
      chk("R4 fill free slot no ev", ev_valid, 0);
    end
    look({20'h00100, 12'h000}, 1'b1);
    chk("R8 write hit", lk_hit, 1);
    for (int i = 1; i < 16; i++) begin
      look({20'h00100 + 20'(i), 12'h010}, 1'b0);
      chk("R4 read hit", lk_hit, 1);
    end
    fill(20'h00200, pf(20'h00200), 1'b0);
    chk("R6 ev valid", ev_valid, 1);
    chk("R4 lru victim", ev_vpn, 20'h00100);
    chk("R7 ref set", ev_ref, 1);
    chk("R8 dirty set by write", ev_dirty, 1);
    fill(20'h00201, pf(20'h00201), 1'b0);
    chk("R4 next victim", ev_vpn, 20'h00101);
    chk("R8 read leaves clean", ev_dirty, 0);
    pulse_clear();
    fill(20'h00202, pf(20'h00202), 1'b0);
    chk("R4 third victim", ev_vpn, 20'h00102);
    chk("R7 ref cleared", ev_ref, 0);
    look({20'h00100, 12'h000}, 1'b0);
    chk("R4 evicted page misses", lk_miss, 1);
  endtask

  task automatic t_refill();
    fill(20'h00200, 20'h12345, 1'b0);
    chk("R5 refill no ev", ev_valid, 0);
    look({20'h00200, 12'h456}, 1'b0);
    chk("R5 new ppn", lk_paddr, {20'h12345, 12'h456});
    fill(20'h00204, pf(20'h00204), 1'b0);
    chk("R5 no stale copy, victim", ev_vpn, 20'h00103);
    chk("R6 ev on full fill", ev_valid, 1);
  endtask

  task automatic t_flush();
    pulse_flush();
    look({20'h00201, 12'h000}, 1'b0);
    chk("R9 flushed misses", lk_miss, 1);
    fill(20'h00205, pf(20'h00205), 1'b1);
    look({20'h00205, 12'h000}, 1'b0);
    chk("R10 fill dropped under flush", lk_miss, 1);
  endtask

  task automatic t_retry();
    look({20'h00300, 12'hFFF}, 1'b0);
    chk("R3 miss before fill", lk_miss, 1);
    fill(20'h00300, pf(20'h00300), 1'b0);
    look({20'h00300, 12'hFFF}, 1'b0);
    chk("R3 retry hits", lk_hit, 1);
    chk("R1 retry paddr", lk_paddr, {pf(20'h00300), 12'hFFF});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_lru_status();
    t_refill();
    t_flush();
    t_retry();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule